// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

This block sits between the execution side and a data cache port. It collects the memory requests of one dynamic wave as they arrive, in whatever order, and hands them to the cache in program order. Each request has its own sequence number and the sequence numbers of the operations before and after it. Either link may be a wildcard when the compiler could not fix it. A request waits in one of the buffer's slots until the ordering rules allow it to go.

Program order is rebuilt from these links, not from arrival age. A request whose predecessor link is a wildcard goes out once an already-issued request names it as its successor. Filler no-op requests keep the chain connected across branches. They retire inside the buffer and never reach the cache. An optional ripple mode lets loads overtake one another. In that mode a load only waits for the most recent earlier store, while stores keep full program order.

A wave-done pulse empties the buffer and clears the issue history, so the next wave starts from scratch.

Top module: `wo_sequencer`

## Requirements
- R1: After reset, req_ready is high and iss_valid is low.
- R2: Requests are accepted in any arrival order. They leave on the issue channel in the order given by their links, with op, sequence number, address and data unchanged. Op codes are load = 0, store = 1, no-op = 2.
- R3: A request whose predecessor field holds a known sequence number becomes eligible only after the request with that number has issued.
- R4: A predecessor field equal to the "none" code (all ones minus one, 14 for 4-bit tags) marks the first operation of the wave. Such a request is eligible at once.
- R5: A predecessor field equal to the wildcard code (all ones, 15 for 4-bit tags) makes the request eligible only after an issued request has named its sequence number as successor.
- R6: A no-op request never raises iss_valid. It retires in the cycle it is selected and then counts as issued for the requests that follow it.
- R7: With ripple_mode high, a load is eligible once its ripple tag (the last earlier store) has issued, or at once if the tag is the "none" code. Loads can therefore overtake earlier loads. Stores and no-ops still follow their predecessor links.
- R8: req_ready is low while all DEPTH slots are occupied, and no request is taken in while it is low.
- R9: At most one request retires per cycle. Among eligible requests, the one with the smallest sequence number goes first.
- R10: A wave_done pulse empties every slot and clears the issue history. After it, a request whose predecessor issued in the old wave is no longer eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wave_done | input | 1 | Pulse: discard all slots and issue history |
| ripple_mode | input | 1 | Loads ordered only against stores |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A slot is free |
| req_op | input | 2 | 0 load, 1 store, 2 no-op |
| req_seq | input | SEQ_W | Own sequence number |
| req_pred | input | SEQ_W | Predecessor sequence number, none or wildcard |
| req_succ | input | SEQ_W | Successor sequence number or wildcard |
| req_rip | input | SEQ_W | Last earlier store sequence number or none |
| req_addr | input | ADDR_W | Memory address |
| req_data | input | DATA_W | Store data |
| iss_valid | output | 1 | Ordered request offered to the cache |
| iss_ready | input | 1 | Cache takes the offered request |
| iss_op | output | 2 | Op of the offered request |
| iss_seq | output | SEQ_W | Sequence number of the offered request |
| iss_addr | output | ADDR_W | Address of the offered request |
| iss_data | output | DATA_W | Data of the offered request |

## Verification
The bench builds the block with 4-bit tags, four slots and 8-bit address and data. At that size a four-long chain fills the buffer, and every one of the 24 arrival orders of that chain can be swept. Each of these runs also checks the full condition. The small tag space makes the none and wildcard codes (14 and 15) cheap to aim at. This allows directed waves that cover wildcard resolution through a successor link, a no-op bridge, ripple-mode overtaking compared with normal mode, smallest-first selection, and history clearing at wave end.

// File: rtl/wo_pkg.sv
package wo_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_NOP   = 2'd2
    } op_e;

endpackage

// File: rtl/wo_free_find.sv
module wo_free_find #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] busy,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);
    // lowest-numbered empty slot
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wo_ready_eval.sv
module wo_ready_eval
    import wo_pkg::*;
#(
    parameter int SEQ_W = 8,
    localparam int NSEQ = 1 << SEQ_W,
    localparam logic [SEQ_W-1:0] TAG_NONE = SEQ_W'(NSEQ - 2),
    localparam logic [SEQ_W-1:0] TAG_UNK  = SEQ_W'(NSEQ - 1)
) (
    input  logic             vld,
    input  op_e              op,
    input  logic [SEQ_W-1:0] seq,
    input  logic [SEQ_W-1:0] pred,
    input  logic [SEQ_W-1:0] rip,
    input  logic             ripple_mode,
    input  logic [NSEQ-1:0]  issued,
    input  logic [NSEQ-1:0]  named,
    output logic             elig
);
    logic link_ok;
    logic store_ok;

    always_comb begin
        if (pred == TAG_NONE) begin
            link_ok = 1'b1;
        end else if (pred == TAG_UNK) begin
            link_ok = named[seq];
        end else begin
            link_ok = issued[pred];
        end

        if (rip == TAG_NONE) begin
            store_ok = 1'b1;
        end else if (rip == TAG_UNK) begin
            store_ok = link_ok;
        end else begin
            store_ok = issued[rip];
        end

        elig = vld && ((ripple_mode && op == OP_LOAD) ? store_ok : link_ok);
    end
endmodule

// File: rtl/wo_oldest_pick.sv
module wo_oldest_pick #(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]       elig,
    input  logic [DEPTH*SEQ_W-1:0] seqs,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (elig[i] && (!hit || seqs[i*SEQ_W +: SEQ_W] < best)) begin
                hit  = 1'b1;
                idx  = IDX_W'(i);
                best = seqs[i*SEQ_W +: SEQ_W];
            end
        end
    end
endmodule

// File: rtl/wo_sequencer.sv
module wo_sequencer
    import wo_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wave_done,
    input  logic              ripple_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [SEQ_W-1:0]  req_seq,
    input  logic [SEQ_W-1:0]  req_pred,
    input  logic [SEQ_W-1:0]  req_succ,
    input  logic [SEQ_W-1:0]  req_rip,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [1:0]        iss_op,
    output logic [SEQ_W-1:0]  iss_seq,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [DATA_W-1:0] iss_data
);
    localparam int NSEQ  = 1 << SEQ_W;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [SEQ_W-1:0] TAG_NONE = SEQ_W'(NSEQ - 2);
    localparam logic [SEQ_W-1:0] TAG_UNK  = SEQ_W'(NSEQ - 1);

    typedef struct packed {
        logic              vld;
        op_e               op;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  pred;
        logic [SEQ_W-1:0]  succ;
        logic [SEQ_W-1:0]  rip;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
        logic  [NSEQ-1:0]  issued;
        logic  [NSEQ-1:0]  named;
    } state_t;

    state_t st_q, st_d;

    logic [DEPTH-1:0]       valid_vec;
    logic [DEPTH-1:0]       elig;
    logic [DEPTH*SEQ_W-1:0] seq_flat;
    logic [NSEQ-1:0]        issued_vec;
    logic                   any_free;
    logic [IDX_W-1:0]       free_idx;
    logic                   sel_hit;
    logic [IDX_W-1:0]       sel_idx;
    logic [SEQ_W-1:0]       sel_pred;
    logic                   sel_nop;
    logic                   fire;
    logic                   accept;

    // per-slot eligibility
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign valid_vec[g]                  = st_q.slot[g].vld;
        assign seq_flat[g*SEQ_W +: SEQ_W]    = st_q.slot[g].seq;

        wo_ready_eval #(.SEQ_W(SEQ_W)) u_eval (
            .vld         (st_q.slot[g].vld),
            .op          (st_q.slot[g].op),
            .seq         (st_q.slot[g].seq),
            .pred        (st_q.slot[g].pred),
            .rip         (st_q.slot[g].rip),
            .ripple_mode (ripple_mode),
            .issued      (st_q.issued),
            .named       (st_q.named),
            .elig        (elig[g])
        );
    end

    wo_free_find #(.DEPTH(DEPTH)) u_free (
        .busy     (valid_vec),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    wo_oldest_pick #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_pick (
        .elig (elig),
        .seqs (seq_flat),
        .hit  (sel_hit),
        .idx  (sel_idx)
    );

    assign issued_vec = st_q.issued;
    assign sel_pred   = st_q.slot[sel_idx].pred;
    assign sel_nop    = (st_q.slot[sel_idx].op == OP_NOP);

    assign iss_valid  = sel_hit && !sel_nop;
    assign iss_op     = st_q.slot[sel_idx].op;
    assign iss_seq    = st_q.slot[sel_idx].seq;
    assign iss_addr   = st_q.slot[sel_idx].addr;
    assign iss_data   = st_q.slot[sel_idx].data;

    assign fire       = sel_hit && (sel_nop || iss_ready);
    assign req_ready  = any_free && !wave_done;
    assign accept     = req_valid && req_ready;

    always_comb begin
        st_d = st_q;

        if (fire) begin
            st_d.slot[sel_idx].vld = 1'b0;
            st_d.issued[st_q.slot[sel_idx].seq] = 1'b1;
            if (st_q.slot[sel_idx].succ != TAG_UNK &&
                st_q.slot[sel_idx].succ != TAG_NONE) begin
                st_d.named[st_q.slot[sel_idx].succ] = 1'b1;
            end
        end

        if (accept) begin
            st_d.slot[free_idx].vld  = 1'b1;
            st_d.slot[free_idx].op   = op_e'(req_op);
            st_d.slot[free_idx].seq  = req_seq;
            st_d.slot[free_idx].pred = req_pred;
            st_d.slot[free_idx].succ = req_succ;
            st_d.slot[free_idx].rip  = req_rip;
            st_d.slot[free_idx].addr = req_addr;
            st_d.slot[free_idx].data = req_data;
        end

        if (wave_done) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wo_sequencer_chk.sv
module wo_sequencer_chk #(
    parameter int SEQ_W = 8,
    parameter int DEPTH = 16,
    localparam int NSEQ = 1 << SEQ_W,
    localparam logic [SEQ_W-1:0] TAG_NONE = SEQ_W'(NSEQ - 2),
    localparam logic [SEQ_W-1:0] TAG_UNK  = SEQ_W'(NSEQ - 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wave_done,
    input logic             ripple_mode,
    input logic             req_ready,
    input logic             iss_valid,
    input logic [1:0]       iss_op,
    input logic [SEQ_W-1:0] sel_pred,
    input logic             fire,
    input logic [DEPTH-1:0] valid_vec,
    input logic [NSEQ-1:0]  issued_vec
);
    // R6: no-ops stay off the issue channel
    a_r6_nop_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> iss_op != 2'd2);

    // R3: a known predecessor has already issued
    a_r3_pred_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !ripple_mode && sel_pred != TAG_NONE && sel_pred != TAG_UNK)
        |-> issued_vec[sel_pred]);

    // R9: exactly one retirement per firing cycle
    a_r9_one_retire: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fire) && !$past(wave_done))
        |-> $countones(issued_vec) == $countones($past(issued_vec)) + 1);

    // R9: history unchanged without a retirement
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fire) && !$past(wave_done)) |-> issued_vec == $past(issued_vec));

    // R8: nothing enters while ready is low
    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(req_ready) && !$past(fire) && !$past(wave_done))
        |-> valid_vec == $past(valid_vec));

    // R10: wave end wipes slots and history
    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wave_done) |-> (valid_vec == '0 && issued_vec == '0 && !iss_valid));
endmodule

bind wo_sequencer wo_sequencer_chk #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wave_done   (wave_done),
    .ripple_mode (ripple_mode),
    .req_ready   (req_ready),
    .iss_valid   (iss_valid),
    .iss_op      (iss_op),
    .sel_pred    (sel_pred),
    .fire        (fire),
    .valid_vec   (valid_vec),
    .issued_vec  (issued_vec)
);

// File: tb/wo_sequencer_tb.sv
`timescale 1ns/1ps
module wo_sequencer_tb;
    localparam int SW = 4;
    localparam int DP = 4;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NONE = 14;
    localparam int UNK  = 15;
    localparam int LD = 0, ST = 1, NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wave_done = 1'b0;
    logic          ripple_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [SW-1:0] req_seq = '0, req_pred = '0, req_succ = '0, req_rip = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          iss_valid;
    logic          iss_ready = 1'b0;
    logic [1:0]    iss_op;
    logic [SW-1:0] iss_seq;
    logic [AW-1:0] iss_addr;
    logic [DW-1:0] iss_data;

    always #10 clk = ~clk;

    wo_sequencer #(.SEQ_W(SW), .DEPTH(DP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wave_done(wave_done), .ripple_mode(ripple_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_seq(req_seq), .req_pred(req_pred), .req_succ(req_succ), .req_rip(req_rip),
        .req_addr(req_addr), .req_data(req_data),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
        .iss_seq(iss_seq), .iss_addr(iss_addr), .iss_data(iss_data)
    );

    int vectors = 0;
    int fails   = 0;
    int got_n   = 0;
    int base    = 0;
    int got_seq [256];
    int got_adr [256];
    int got_dat [256];
    int got_op  [256];
    int op_of   [16];

    // transfer log, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && iss_valid && iss_ready && got_n < 256) begin
            got_seq[got_n] = int'(iss_seq);
            got_adr[got_n] = int'(iss_addr);
            got_dat[got_n] = int'(iss_data);
            got_op[got_n]  = int'(iss_op);
            got_n = got_n + 1;
        end
    end

    initial begin
        #4000000;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
        $finish;
    end

    function automatic int addr_of(int s); return (s * 3 + 7) & 8'hff; endfunction
    function automatic int data_of(int s); return (s ^ 8'h5a) & 8'hff; endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(int op, int s, int p, int n, int r);
        @(posedge clk); #1;
        req_op = 2'(op); req_seq = SW'(s); req_pred = SW'(p);
        req_succ = SW'(n); req_rip = SW'(r);
        req_addr = AW'(addr_of(s)); req_data = DW'(data_of(s));
        op_of[s] = op;
        req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic set_rdy(bit v);
        @(posedge clk); #1; iss_ready = v;
    endtask

    task automatic pulse_done();
        @(posedge clk); #1; wave_done = 1'b1;
        @(posedge clk); #1; wave_done = 1'b0;
    endtask

    task automatic expect_log(string tag, int n, int e0, int e1, int e2, int e3);
        int e [4];
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        check(got_n - base == n, {tag, " count"}, got_n - base, n);
        for (int i = 0; i < n && i < got_n - base; i++) begin
            int k;
            k = base + i;
            check(got_seq[k] == e[i], {tag, " seq"}, got_seq[k], e[i]);
            check(got_adr[k] == addr_of(e[i]), {tag, " R2 addr"}, got_adr[k], addr_of(e[i]));
            check(got_dat[k] == data_of(e[i]), {tag, " R2 data"}, got_dat[k], data_of(e[i]));
            check(got_op[k] == op_of[e[i]], {tag, " R2 op"}, got_op[k], op_of[e[i]]);
        end
        base = got_n;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(iss_valid == 1'b0, "R1 idle after reset", int'(iss_valid), 0);

        // R2 R3 R4 R8: every arrival order of a four-long chain
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
        for (int d = 0; d < 4; d++) begin
            if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                int perm [4];
                perm[0] = a; perm[1] = b; perm[2] = c; perm[3] = d;
                set_rdy(1'b0);
                for (int i = 0; i < 4; i++) begin
                    int k;
                    k = perm[i];
                    send(k[0] ? ST : LD, k, (k == 0) ? NONE : k - 1,
                         (k == 3) ? UNK : k + 1, NONE);
                end
                @(negedge clk);
                check(req_ready == 1'b0, "R8 ready low when full", int'(req_ready), 0);
                set_rdy(1'b1);
                repeat (8) @(posedge clk);
                expect_log("R2 R3 chain order", 4, 0, 1, 2, 3);
                pulse_done();
            end
        end

        // R5: wildcard predecessor resolved by a successor link
        set_rdy(1'b1);
        send(ST, 3, UNK, UNK, NONE);
        repeat (4) @(posedge clk);
        expect_log("R5 wildcard waits", 0, 0, 0, 0, 0);
        send(LD, 0, NONE, UNK, NONE);
        repeat (4) @(posedge clk);
        expect_log("R5 R4 head only", 1, 0, 0, 0, 0);
        send(LD, 1, 0, 3, NONE);
        repeat (6) @(posedge clk);
        expect_log("R5 resolved", 2, 1, 3, 0, 0);
        pulse_done();

        // R6: no-op bridge retires silently
        send(NP, 1, 0, 2, NONE);
        send(ST, 2, UNK, UNK, NONE);
        repeat (4) @(posedge clk);
        expect_log("R6 nothing yet", 0, 0, 0, 0, 0);
        send(LD, 0, NONE, UNK, NONE);
        repeat (8) @(posedge clk);
        expect_log("R6 nop hidden", 2, 0, 2, 0, 0);
        pulse_done();

        // R7: ripple mode lets a load overtake
        ripple_mode = 1'b1;
        send(LD, 2, 1, 3, 0);
        repeat (3) @(posedge clk);
        expect_log("R7 load waits for store", 0, 0, 0, 0, 0);
        send(ST, 0, NONE, 1, NONE);
        repeat (6) @(posedge clk);
        expect_log("R7 overtake", 2, 0, 2, 0, 0);
        send(LD, 1, 0, 2, 0);
        send(ST, 3, 2, UNK, 0);
        repeat (6) @(posedge clk);
        expect_log("R7 store keeps chain", 2, 1, 3, 0, 0);
        pulse_done();

        // R7 contrast: normal mode holds the same load
        ripple_mode = 1'b0;
        send(LD, 2, 1, 3, 0);
        send(ST, 0, NONE, 1, NONE);
        repeat (6) @(posedge clk);
        expect_log("R7 normal mode holds", 1, 0, 0, 0, 0);
        send(LD, 1, 0, 2, 0);
        repeat (6) @(posedge clk);
        expect_log("R7 normal mode order", 2, 1, 2, 0, 0);
        pulse_done();

        // R9: smallest sequence number first among eligible
        ripple_mode = 1'b1;
        set_rdy(1'b0);
        send(LD, 5, 4, 6, NONE);
        send(LD, 3, 2, 4, NONE);
        send(LD, 9, 8, UNK, NONE);
        set_rdy(1'b1);
        repeat (8) @(posedge clk);
        expect_log("R9 oldest first", 3, 3, 5, 9, 0);
        pulse_done();
        ripple_mode = 1'b0;

        // R10: history from an old wave is gone
        send(LD, 0, NONE, 1, NONE);
        repeat (4) @(posedge clk);
        expect_log("R10 old wave", 1, 0, 0, 0, 0);
        pulse_done();
        send(LD, 1, 0, UNK, NONE);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(iss_valid == 1'b0, "R10 history cleared", int'(iss_valid), 0);
        expect_log("R10 no issue", 0, 0, 0, 0, 0);
        pulse_done();
        @(negedge clk);
        check(req_ready == 1'b1, "R10 slots freed", int'(req_ready), 1);
        check(iss_valid == 1'b0, "R10 idle after clear", int'(iss_valid), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule